// File: doc/BRIEF.md
# Operand Collector Unit Set

This block is a pool of collector units that sits between instruction decode and the execution pipeline registers. Each unit takes one decoded warp instruction together with up to four source register indices and the index of the output register it must later be written to. It then waits until every valid source operand has been delivered. A register index counts as valid when its two's-complement value is non-negative. Operand deliveries come from the register-file read path as single-cycle pulses, each tagged with a unit number and an operand slot number.

A unit becomes ready once it is busy, none of its operands are pending and its bound output register reports empty. One or more round-robin dispatchers, all serving this set, pick among the ready units. A pick shows at the dispatch ports in the same cycle, and the unit is free again from the next clock edge. The caller uses the per-unit busy flags to choose a free unit for the next allocation. Register-bank reading and bank arbitration stay outside the block.

Top module: `oc_unit_set`

## Requirements
- R1: After reset every unit is free (`cu_busy` all zero), no dispatcher reports a pick, and every dispatcher pointer is 0, so the first search starts at unit 1.
- R2: An allocation (`alloc_valid` high, unit `alloc_cu`) is taken at the clock edge only if that unit is free. From the next cycle the unit is busy and holds the warp ID, the instruction word and the output register index. An allocation that names a busy unit is ignored and leaves that unit's contents unchanged. This includes a unit that is being dispatched in the same cycle.
- R3: Operand slot k is taken from `alloc_regs[k*REG_W +: REG_W]`. The slot is pending after allocation only when bit `REG_W-1` of that field is 0 (non-negative index). A negative index sets no pending bit. A unit with no valid slots is ready in the cycle after allocation.
- R4: An arrival pulse (`op_valid`, `op_cu`, `op_idx`) clears the pending bit of slot `op_idx` in unit `op_cu` at the clock edge. An arrival for a slot that is not pending has no effect.
- R5: A unit is ready only when it is busy, has no pending slots and `out_empty` of its bound output register is 1. A pick drives `disp_valid`, the unit number, the output register index, the warp ID and the instruction word on that dispatcher's slice in the same cycle.
- R6: A dispatched unit is free from the next cycle, with its pending slots and output binding cleared, and it can be allocated again.
- R7: Dispatcher d checks units last_d+1, last_d+2, … modulo `NUM_CU`, picks the first one it is allowed to take, and sets last_d to that unit. When it picks nothing, last_d is unchanged.
- R8: Each dispatcher picks at most one unit per cycle. Dispatcher d skips any unit picked by a lower-numbered dispatcher in that cycle, and any unit bound to an output register that a lower-numbered dispatcher writes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_cu | input | CU_W | Unit to allocate |
| alloc_warp | input | WARP_W | Warp ID of the instruction |
| alloc_instr | input | INSTR_W | Instruction payload |
| alloc_regs | input | NUM_OPS*REG_W | Source register indices, slot k at bits k*REG_W |
| alloc_out | input | OUT_W | Output register the unit dispatches to |
| op_valid | input | 1 | Operand arrival pulse |
| op_cu | input | CU_W | Unit receiving the operand |
| op_idx | input | OP_W | Operand slot that arrived |
| out_empty | input | NUM_OUT | Empty flag of each output register |
| cu_busy | output | NUM_CU | Per-unit busy flag |
| disp_valid | output | NUM_DISP | Dispatcher made a pick this cycle |
| disp_cu | output | NUM_DISP*CU_W | Picked unit per dispatcher |
| disp_out | output | NUM_DISP*OUT_W | Output register written per dispatcher |
| disp_warp | output | NUM_DISP*WARP_W | Warp ID moved per dispatcher |
| disp_instr | output | NUM_DISP*INSTR_W | Instruction moved per dispatcher |

## Verification
A pending bit that is stuck set shows up as a unit that stays busy and never appears on the dispatch ports. A bit that fails to be set shows up as a dispatch one or more cycles earlier than the operand deliveries allow. A damaged round-robin pointer or dispatcher chain first appears in the cycle where two or more units are ready together: the wrong unit number, or two dispatchers picking the same unit or the same output register. A stale binding or payload shows up as the wrong output index or warp ID on the dispatch that finishes that allocation. Because dispatch is combinational on the registered state, every one of these errors is visible in the very cycle it takes effect.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic {
    CU_FREE = 1'b0,
    CU_BUSY = 1'b1
  } cu_state_e;

  // next index in a ring of n entries
  function automatic int unsigned rr_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // a source index is usable when its sign bit is clear
  function automatic logic src_is_valid(logic sign_bit);
    return ~sign_bit;
  endfunction

endpackage

// File: rtl/oc_cu_slot.sv
module oc_cu_slot
  import oc_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int NUM_OUT = 2,
  parameter int REG_W   = 6,
  parameter int WARP_W  = 5,
  parameter int INSTR_W = 12,
  parameter int OUT_W   = 1,
  parameter int OP_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_hit,
  input  logic [WARP_W-1:0]        alloc_warp,
  input  logic [INSTR_W-1:0]       alloc_instr,
  input  logic [NUM_OPS*REG_W-1:0] alloc_regs,
  input  logic [OUT_W-1:0]         alloc_out,
  input  logic                     op_hit,
  input  logic [OP_W-1:0]          op_idx,
  input  logic                     disp_hit,
  input  logic [NUM_OUT-1:0]       out_empty,
  output logic                     busy,
  output logic                     ready,
  output logic [NUM_OPS-1:0]       pend,
  output logic [OUT_W-1:0]         osel,
  output logic [WARP_W-1:0]        warp,
  output logic [INSTR_W-1:0]       instr
);

  cu_state_e          st;
  logic [NUM_OPS-1:0] vmask;
  logic               alloc_take;

  genvar k;
  for (k = 0; k < NUM_OPS; k++) begin : g_vld
    assign vmask[k] = src_is_valid(alloc_regs[k*REG_W + REG_W - 1]);
  end

  assign alloc_take = alloc_hit && (st == CU_FREE) && (pend == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= CU_FREE;
      pend  <= '0;
      osel  <= '0;
      warp  <= '0;
      instr <= '0;
    end else if (disp_hit) begin
      st    <= CU_FREE;
      pend  <= '0;
      osel  <= '0;
    end else if (alloc_take) begin
      st    <= CU_BUSY;
      pend  <= vmask;
      osel  <= alloc_out;
      warp  <= alloc_warp;
      instr <= alloc_instr;
    end else if (op_hit) begin
      pend[op_idx] <= 1'b0;
    end
  end

  assign busy  = (st == CU_BUSY);
  assign ready = busy && (pend == '0) && out_empty[osel];

endmodule

// File: rtl/oc_rr_arb.sv
module oc_rr_arb
  import oc_pkg::*;
#(
  parameter int NUM_CU = 4,
  parameter int CU_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CU-1:0] cand,
  output logic              gnt_valid,
  output logic [CU_W-1:0]   gnt_idx
);

  logic [CU_W-1:0] last;

  always_comb begin
    int unsigned idx;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    idx       = int'(last);
    for (int k = 0; k < NUM_CU; k++) begin
      idx = rr_next(idx, NUM_CU);
      if (!gnt_valid && cand[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CU_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last <= '0;
    else if (gnt_valid) last <= gnt_idx;
  end

endmodule

// File: rtl/oc_unit_set.sv
module oc_unit_set
  import oc_pkg::*;
#(
  parameter int NUM_CU   = 4,
  parameter int NUM_DISP = 2,
  parameter int NUM_OPS  = 4,
  parameter int NUM_OUT  = 2,
  parameter int REG_W    = 6,
  parameter int WARP_W   = 5,
  parameter int INSTR_W  = 12,
  localparam int CU_W    = (NUM_CU  > 1) ? $clog2(NUM_CU)  : 1,
  localparam int OUT_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int OP_W    = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  input  logic [CU_W-1:0]              alloc_cu,
  input  logic [WARP_W-1:0]            alloc_warp,
  input  logic [INSTR_W-1:0]           alloc_instr,
  input  logic [NUM_OPS*REG_W-1:0]     alloc_regs,
  input  logic [OUT_W-1:0]             alloc_out,
  input  logic                         op_valid,
  input  logic [CU_W-1:0]              op_cu,
  input  logic [OP_W-1:0]              op_idx,
  input  logic [NUM_OUT-1:0]           out_empty,
  output logic [NUM_CU-1:0]            cu_busy,
  output logic [NUM_DISP-1:0]          disp_valid,
  output logic [NUM_DISP*CU_W-1:0]     disp_cu,
  output logic [NUM_DISP*OUT_W-1:0]    disp_out,
  output logic [NUM_DISP*WARP_W-1:0]   disp_warp,
  output logic [NUM_DISP*INSTR_W-1:0]  disp_instr
);

  logic [NUM_CU-1:0]         cu_ready;
  logic [NUM_CU-1:0]         disp_hit_mask;
  logic [NUM_CU*NUM_OPS-1:0] slot_pend;
  logic [OUT_W-1:0]          cu_osel  [NUM_CU];
  logic [WARP_W-1:0]         cu_warp  [NUM_CU];
  logic [INSTR_W-1:0]        cu_instr [NUM_CU];

  genvar i, d;
  for (i = 0; i < NUM_CU; i++) begin : g_cu
    oc_cu_slot #(
      .NUM_OPS(NUM_OPS), .NUM_OUT(NUM_OUT), .REG_W(REG_W), .WARP_W(WARP_W),
      .INSTR_W(INSTR_W), .OUT_W(OUT_W), .OP_W(OP_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_hit  (alloc_valid && (alloc_cu == CU_W'(i))),
      .alloc_warp (alloc_warp),
      .alloc_instr(alloc_instr),
      .alloc_regs (alloc_regs),
      .alloc_out  (alloc_out),
      .op_hit     (op_valid && (op_cu == CU_W'(i))),
      .op_idx     (op_idx),
      .disp_hit   (disp_hit_mask[i]),
      .out_empty  (out_empty),
      .busy       (cu_busy[i]),
      .ready      (cu_ready[i]),
      .pend       (slot_pend[i*NUM_OPS +: NUM_OPS]),
      .osel       (cu_osel[i]),
      .warp       (cu_warp[i]),
      .instr      (cu_instr[i])
    );
  end

  // dispatchers are chained: each sees what the lower ones already took
  for (d = 0; d < NUM_DISP; d++) begin : g_disp
    logic [NUM_CU-1:0]  prev_cu, cand, taken_cu;
    logic [NUM_OUT-1:0] prev_out, taken_out;
    logic               gv;
    logic [CU_W-1:0]    gi;

    if (d == 0) begin : g_head
      assign prev_cu  = '0;
      assign prev_out = '0;
    end else begin : g_link
      assign prev_cu  = g_disp[d-1].taken_cu;
      assign prev_out = g_disp[d-1].taken_out;
    end

    always_comb begin
      for (int u = 0; u < NUM_CU; u++)
        cand[u] = cu_ready[u] && !prev_cu[u] && !prev_out[cu_osel[u]];
    end

    oc_rr_arb #(.NUM_CU(NUM_CU), .CU_W(CU_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand     (cand),
      .gnt_valid(gv),
      .gnt_idx  (gi)
    );

    assign taken_cu  = prev_cu  | (gv ? (NUM_CU'(1)  << gi)          : '0);
    assign taken_out = prev_out | (gv ? (NUM_OUT'(1) << cu_osel[gi]) : '0);

    assign disp_valid[d]                       = gv;
    assign disp_cu[d*CU_W +: CU_W]             = gi;
    assign disp_out[d*OUT_W +: OUT_W]          = cu_osel[gi];
    assign disp_warp[d*WARP_W +: WARP_W]       = cu_warp[gi];
    assign disp_instr[d*INSTR_W +: INSTR_W]    = cu_instr[gi];
  end

  assign disp_hit_mask = g_disp[NUM_DISP-1].taken_cu;

endmodule

// File: rtl/oc_unit_set_chk.sv
module oc_unit_set_chk #(
  parameter int NUM_CU   = 4,
  parameter int NUM_DISP = 2,
  parameter int NUM_OPS  = 4,
  parameter int NUM_OUT  = 2,
  parameter int CU_W     = 2,
  parameter int OUT_W    = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      alloc_valid,
  input logic [CU_W-1:0]           alloc_cu,
  input logic [NUM_OUT-1:0]        out_empty,
  input logic [NUM_CU-1:0]         cu_busy,
  input logic [NUM_CU-1:0]         disp_hit_mask,
  input logic [NUM_CU*NUM_OPS-1:0] slot_pend,
  input logic [NUM_DISP-1:0]       disp_valid,
  input logic [NUM_DISP*CU_W-1:0]  disp_cu,
  input logic [NUM_DISP*OUT_W-1:0] disp_out
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_busy == '0) |-> (disp_valid == '0));

  p_alloc_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !cu_busy[alloc_cu]) |=> cu_busy[$past(alloc_cu)]);

  p_pick_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_hit_mask) == $countones(disp_valid));

  genvar u, d, e;
  for (u = 0; u < NUM_CU; u++) begin : g_u
    p_free_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
      disp_hit_mask[u] |=> !cu_busy[u]);
    p_fall_by_disp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cu_busy[u]) |-> $past(disp_hit_mask[u]));
  end

  for (d = 0; d < NUM_DISP; d++) begin : g_d
    p_out_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[d] |-> (out_empty[disp_out[d*OUT_W +: OUT_W]] &&
                         cu_busy[disp_cu[d*CU_W +: CU_W]]));
    p_no_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[d] |-> (slot_pend[disp_cu[d*CU_W +: CU_W]*NUM_OPS +: NUM_OPS] == '0));
    for (e = d + 1; e < NUM_DISP; e++) begin : g_e
      p_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[d] && disp_valid[e]) |->
          ((disp_cu[d*CU_W +: CU_W] != disp_cu[e*CU_W +: CU_W]) &&
           (disp_out[d*OUT_W +: OUT_W] != disp_out[e*OUT_W +: OUT_W])));
    end
  end

endmodule

bind oc_unit_set oc_unit_set_chk #(
  .NUM_CU(NUM_CU), .NUM_DISP(NUM_DISP), .NUM_OPS(NUM_OPS),
  .NUM_OUT(NUM_OUT), .CU_W(CU_W), .OUT_W(OUT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_cu     (alloc_cu),
  .out_empty    (out_empty),
  .cu_busy      (cu_busy),
  .disp_hit_mask(disp_hit_mask),
  .slot_pend    (slot_pend),
  .disp_valid   (disp_valid),
  .disp_cu      (disp_cu),
  .disp_out     (disp_out)
);

// File: tb/tb_oc_unit_set.sv
module tb_oc_unit_set;
  localparam int NUM_CU = 4, NUM_DISP = 2, NUM_OPS = 4, NUM_OUT = 2;
  localparam int REG_W = 6, WARP_W = 5, INSTR_W = 12;
  localparam int CU_W = 2, OUT_W = 1, OP_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                         alloc_valid = 0;
  logic [CU_W-1:0]              alloc_cu = '0;
  logic [WARP_W-1:0]            alloc_warp = '0;
  logic [INSTR_W-1:0]           alloc_instr = '0;
  logic [NUM_OPS*REG_W-1:0]     alloc_regs = '0;
  logic [OUT_W-1:0]             alloc_out = '0;
  logic                         op_valid = 0;
  logic [CU_W-1:0]              op_cu = '0;
  logic [OP_W-1:0]              op_idx = '0;
  logic [NUM_OUT-1:0]           out_empty = '1;
  logic [NUM_CU-1:0]            cu_busy;
  logic [NUM_DISP-1:0]          disp_valid;
  logic [NUM_DISP*CU_W-1:0]     disp_cu;
  logic [NUM_DISP*OUT_W-1:0]    disp_out;
  logic [NUM_DISP*WARP_W-1:0]   disp_warp;
  logic [NUM_DISP*INSTR_W-1:0]  disp_instr;

  oc_unit_set #(
    .NUM_CU(NUM_CU), .NUM_DISP(NUM_DISP), .NUM_OPS(NUM_OPS), .NUM_OUT(NUM_OUT),
    .REG_W(REG_W), .WARP_W(WARP_W), .INSTR_W(INSTR_W)
  ) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  bit                 m_busy  [NUM_CU];
  bit [NUM_OPS-1:0]   m_pend  [NUM_CU];
  int                 m_osel  [NUM_CU];
  int                 m_warp  [NUM_CU];
  int                 m_instr [NUM_CU];
  int                 m_last  [NUM_DISP];
  bit                 m_full  [NUM_OUT];
  bit [NUM_OUT-1:0]   drain = '1;

  localparam logic [NUM_OPS*REG_W-1:0] ALL_VALID = {6'd9, 6'd3, 6'd2, 6'd1};
  localparam logic [NUM_OPS*REG_W-1:0] ALL_NEG   = {4{6'h3F}};
  localparam logic [NUM_OPS*REG_W-1:0] MIXED     = {6'h3F, 6'd7, 6'h20, 6'd0};

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM_CU; i++) begin
      m_busy[i] = 0; m_pend[i] = '0; m_osel[i] = 0; m_warp[i] = 0; m_instr[i] = 0;
    end
    for (int d = 0; d < NUM_DISP; d++) m_last[d] = 0;
    for (int o = 0; o < NUM_OUT; o++) m_full[o] = 0;
  endtask

  // called just after a falling edge with inputs already driven
  task automatic cycle(string tag);
    int  pick [NUM_DISP];
    bit  used_cu [NUM_CU];
    bit  used_out [NUM_OUT];
    bit  was_busy [NUM_CU];
    bit  wrote [NUM_OUT];
    for (int o = 0; o < NUM_OUT; o++) begin
      out_empty[o] = !m_full[o]; used_out[o] = 0; wrote[o] = 0;
    end
    for (int i = 0; i < NUM_CU; i++) begin used_cu[i] = 0; was_busy[i] = m_busy[i]; end
    #1;
    for (int d = 0; d < NUM_DISP; d++) begin
      pick[d] = -1;
      for (int k = 1; k <= NUM_CU; k++) begin
        int c;
        c = (m_last[d] + k) % NUM_CU;
        if (pick[d] < 0 && m_busy[c] && m_pend[c] == 0 && !m_full[m_osel[c]] &&
            !used_cu[c] && !used_out[m_osel[c]])
          pick[d] = c;
      end
      if (pick[d] >= 0) begin used_cu[pick[d]] = 1; used_out[m_osel[pick[d]]] = 1; end
    end
    for (int i = 0; i < NUM_CU; i++) chk(tag, "cu_busy", 64'(cu_busy[i]), 64'(m_busy[i]));
    for (int d = 0; d < NUM_DISP; d++) begin
      chk(tag, "disp_valid", 64'(disp_valid[d]), 64'(pick[d] >= 0));
      if (pick[d] >= 0) begin
        chk(tag, "disp_cu",    64'(disp_cu[d*CU_W +: CU_W]),          64'(pick[d]));
        chk(tag, "disp_out",   64'(disp_out[d*OUT_W +: OUT_W]),       64'(m_osel[pick[d]]));
        chk(tag, "disp_warp",  64'(disp_warp[d*WARP_W +: WARP_W]),    64'(m_warp[pick[d]]));
        chk(tag, "disp_instr", 64'(disp_instr[d*INSTR_W +: INSTR_W]), 64'(m_instr[pick[d]]));
      end
    end
    @(posedge clk);
    for (int d = 0; d < NUM_DISP; d++)
      if (pick[d] >= 0) begin
        wrote[m_osel[pick[d]]] = 1;
        m_busy[pick[d]] = 0; m_pend[pick[d]] = '0; m_osel[pick[d]] = 0;
        m_last[d] = pick[d];
      end
    for (int o = 0; o < NUM_OUT; o++)
      m_full[o] = wrote[o] ? 1'b1 : (drain[o] ? 1'b0 : m_full[o]);
    if (op_valid) m_pend[op_cu][op_idx] = 1'b0;
    if (alloc_valid && !was_busy[alloc_cu]) begin
      m_busy[alloc_cu] = 1;
      m_osel[alloc_cu] = alloc_out;
      m_warp[alloc_cu] = alloc_warp;
      m_instr[alloc_cu] = alloc_instr;
      for (int k = 0; k < NUM_OPS; k++)
        m_pend[alloc_cu][k] = ($signed(alloc_regs[k*REG_W +: REG_W]) >= 0);
    end
    @(negedge clk);
  endtask

  task automatic put_alloc(int c, int w, int ins, logic [NUM_OPS*REG_W-1:0] r, int o);
    alloc_valid = 1; alloc_cu = CU_W'(c); alloc_warp = WARP_W'(w);
    alloc_instr = INSTR_W'(ins); alloc_regs = r; alloc_out = OUT_W'(o);
  endtask

  task automatic put_op(int c, int k);
    op_valid = 1; op_cu = CU_W'(c); op_idx = OP_W'(k);
  endtask

  task automatic quiet();
    alloc_valid = 0; op_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing busy, nothing picked
    cycle("R1"); cycle("R1");

    // R2: allocation of a free unit
    put_alloc(2, 5'h11, 12'hABC, ALL_VALID, 0); cycle("R2");
    quiet(); cycle("R2");
    // R4: arrivals one by one, plus one for a free unit
    put_op(2, 0); cycle("R4");
    put_op(0, 1); cycle("R4");
    put_op(2, 1); cycle("R4");
    put_op(2, 2); cycle("R4");
    put_op(2, 3); cycle("R4");
    // R5: ready now, dispatched this cycle; R6: free next
    quiet(); cycle("R5");
    cycle("R6");

    // R3: mixed valid/negative slots
    put_alloc(1, 5'h03, 12'h123, MIXED, 1); cycle("R3");
    put_op(1, 1); cycle("R3");
    put_op(1, 3); cycle("R3");
    put_op(1, 0); cycle("R3");
    quiet(); cycle("R3");
    put_op(1, 2); cycle("R3");
    quiet(); cycle("R3"); cycle("R3");
    put_alloc(0, 5'h07, 12'h777, ALL_NEG, 1); cycle("R3");
    quiet(); cycle("R3"); cycle("R3");

    // R2: second allocation to a busy unit is ignored
    put_alloc(3, 5'h01, 12'h111, ALL_VALID, 0); cycle("R2");
    put_alloc(3, 5'h02, 12'h222, ALL_NEG, 1); cycle("R2");
    quiet();
    for (int k = 0; k < NUM_OPS; k++) begin put_op(3, k); cycle("R2"); end
    quiet(); cycle("R2"); cycle("R6");

    // R5: a full output register holds back a ready unit
    drain = '0;
    put_alloc(0, 5'h0A, 12'h0A0, ALL_NEG, 0); cycle("R5");
    put_alloc(1, 5'h0B, 12'h0B0, ALL_NEG, 0); cycle("R5");
    quiet(); cycle("R5"); cycle("R5"); cycle("R5");
    drain = '1; cycle("R5"); cycle("R5"); cycle("R5"); cycle("R5");

    // R8: several ready at once behind full registers, then released together
    drain = '0;
    put_alloc(0, 5'h10, 12'h100, ALL_NEG, 0); cycle("R8");
    put_alloc(1, 5'h11, 12'h101, ALL_NEG, 1); cycle("R8");
    put_alloc(2, 5'h12, 12'h102, ALL_NEG, 0); cycle("R8");
    put_alloc(3, 5'h13, 12'h103, ALL_NEG, 1); cycle("R8");
    quiet(); cycle("R8");
    drain = '1;
    for (int n = 0; n < 6; n++) cycle("R7");

    // R7 R8: mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NUM_OPS*REG_W-1:0] r;
      for (int k = 0; k < NUM_OPS; k++)
        r[k*REG_W +: REG_W] = ($urandom_range(0, 9) < 4) ? REG_W'(6'h20 | $urandom_range(0, 31))
                                                       : REG_W'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1)
        put_alloc($urandom_range(0, NUM_CU-1), $urandom_range(0, 31),
                  $urandom_range(0, 4095), r, $urandom_range(0, NUM_OUT-1));
      else alloc_valid = 0;
      if ($urandom_range(0, 9) < 6) put_op($urandom_range(0, NUM_CU-1), $urandom_range(0, NUM_OPS-1));
      else op_valid = 0;
      drain = NUM_OUT'($urandom_range(0, (1 << NUM_OUT) - 1));
      cycle("R4 R7 R8");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule